// File: doc/BRIEF.md
# Debug Port Mode-Switch Detector

This block sits on the target side of a debug port where JTAG and a two-wire serial debug protocol share one clock pin and one mode/data pin. On every rising edge of the port clock it samples the shared data pin. From that bit stream it decides which of the two protocols currently owns the port. It flips that decision only when the host sends a proper switch sequence: a long run of high samples followed by a 16-bit code for the opposite direction.

The block drives three outputs. The first is a level flag telling downstream logic which protocol is active. The second is a one-cycle pulse when the serial-wire link must perform a line reset. The third is a one-cycle pulse when the mode has just changed. Instruction decode, TAP registers, packet handling and turnaround all stay in downstream logic. Reset is synchronous and active high, and it is expected to be driven from power-on reset.

Top module: `dbg_mode_switch_detector`

## Requirements
- R1: During and right after reset, the mode flag reads 0 (JTAG) and both pulse outputs read 0.
- R2: Consecutive high samples are counted, and any low sample clears the count. A code is considered only when it directly follows an unbroken run of at least 50 high samples.
- R3: In JTAG mode, a qualifying run followed by the 16 bits of 16'hE79E, taken least significant bit first (bit 0 is the first sample after the run), sets the mode flag to 1 (serial-wire). This takes effect on the clock edge that samples the code's last bit, and mode-changed is high for exactly that one following cycle.
- R4: In serial-wire mode, a qualifying run followed by 16'hE73C, taken least significant bit first, returns the mode flag to 0. Mode-changed pulses for one cycle in the same way.
- R5: A code preceded by only 49 high samples changes nothing.
- R6: A sample that differs from the expected code bit abandons the code. A correct code sent straight after it, with no new run of at least 50 highs, is ignored.
- R7: The code for the direction the port is already in has no effect: there is no mode change and no mode-changed pulse.
- R8: In serial-wire mode, the edge that samples the 50th consecutive high produces a one-cycle line-reset pulse. A longer run produces no further pulses. No line-reset pulse is produced in JTAG mode.
- R9: The trailing high run is not required: the mode flag is already updated in the cycle after the last code bit.
- R10: The high-run count saturates, so a run of any length (for example 300) still qualifies a following code.
- R11: After an accepted code, a further code needs its own new qualifying run. A code sent immediately after an accepted one is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared debug port clock; the data pin is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dio_i | input | 1 | Shared mode/data pin, already brought into the clock domain |
| port_serial_o | output | 1 | 1 when the serial-wire protocol owns the port, 0 for JTAG |
| line_reset_o | output | 1 | One-cycle pulse requesting a serial-wire line reset |
| mode_changed_o | output | 1 | One-cycle pulse following a mode flip |

## Verification
The assertions check several properties on every cycle. The run counter never passes its limit, clears after a low sample and steps by one on a high. The mode flag flips only with a mode-changed pulse, and never without one. Both pulses last a single cycle, and a line-reset pulse occurs only in serial-wire mode. The code collector leaves its collecting state as soon as a code completes. What the assertions cannot see is whether the right bit stream was accepted. The direction-specific codes, the exact 50-sample threshold, abandonment on a wrong bit, and the need for a fresh run after an accepted or rejected code are shown only by the bench's scenarios, checked against its history-based reference model.

// File: rtl/dbgsw_pkg.sv
package dbgsw_pkg;

    localparam int unsigned DFLT_RUN_LEN = 50;
    localparam int unsigned SW_CODE_W    = 16;

    localparam logic [SW_CODE_W-1:0] CODE_JTAG_TO_SERIAL = 16'hE79E;
    localparam logic [SW_CODE_W-1:0] CODE_SERIAL_TO_JTAG = 16'hE73C;

    typedef enum logic [1:0] {
        MS_IDLE    = 2'd0,
        MS_ARMED   = 2'd1,
        MS_COLLECT = 2'd2
    } match_st_e;

    typedef enum logic {
        PORT_JTAG   = 1'b0,
        PORT_SERIAL = 1'b1
    } port_mode_e;

    typedef struct packed {
        port_mode_e mode;
        logic       line_rst;
        logic       mode_chg;
    } port_status_t;

    // The only code accepted from a given mode is the one leading away from it.
    function automatic logic [SW_CODE_W-1:0] code_for_exit(
        input port_mode_e                cur,
        input logic [SW_CODE_W-1:0]      to_serial,
        input logic [SW_CODE_W-1:0]      to_jtag
    );
        return (cur == PORT_SERIAL) ? to_jtag : to_serial;
    endfunction

endpackage

// File: rtl/hi_run_tracker.sv
module hi_run_tracker #(
    parameter int unsigned RUN_LEN = dbgsw_pkg::DFLT_RUN_LEN,
    localparam int unsigned CW     = $clog2(RUN_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dio,
    output logic [CW-1:0] run_cnt,
    output logic          arm_now,
    output logic          reach_now
);
    localparam logic [CW-1:0] CNT_MAX  = CW'(RUN_LEN);
    localparam logic [CW-1:0] CNT_LAST = CW'(RUN_LEN - 1);

    // This sample keeps or brings the run at or beyond the limit.
    assign arm_now   = dio && (run_cnt >= CNT_LAST);
    // This sample is exactly the one that completes the run.
    assign reach_now = dio && (run_cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (!dio) begin
            run_cnt <= '0;
        end else if (run_cnt != CNT_MAX) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= CNT_MAX);

    assert_low_clears_R2: assert property (@(posedge clk) disable iff (rst)
        !dio |=> (run_cnt == '0));

    assert_high_steps_R2: assert property (@(posedge clk) disable iff (rst)
        (dio && run_cnt < CNT_MAX) |=> (run_cnt == $past(run_cnt) + 1'b1));

endmodule

// File: rtl/code_matcher.sv
module code_matcher #(
    parameter int unsigned CODE_W = dbgsw_pkg::SW_CODE_W,
    localparam int unsigned IW    = $clog2(CODE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dio,
    input  logic              arm_now,
    input  logic [CODE_W-1:0] exp_code,
    output logic              code_hit
);
    import dbgsw_pkg::*;

    localparam logic [IW-1:0] IDX_LAST = IW'(CODE_W - 1);

    match_st_e         state;
    logic [IW-1:0]     idx;
    logic [CODE_W-1:0] shreg;
    logic              bit_ok;

    assign bit_ok   = (dio == exp_code[idx]);
    assign code_hit = (state == MS_COLLECT) && bit_ok && (idx == IDX_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= MS_IDLE;
            idx   <= '0;
            shreg <= '0;
        end else begin
            unique case (state)
                MS_IDLE: begin
                    idx <= '0;
                    if (arm_now) state <= MS_ARMED;
                end
                MS_ARMED: begin
                    // Highs only extend the run; the first low opens the code.
                    if (!dio) begin
                        if (exp_code[0] == dio) begin
                            state <= MS_COLLECT;
                            idx   <= IW'(1);
                            shreg <= {dio, shreg[CODE_W-1:1]};
                        end else begin
                            state <= MS_IDLE;
                        end
                    end
                end
                MS_COLLECT: begin
                    if (!bit_ok) begin
                        state <= MS_IDLE;
                        idx   <= '0;
                    end else begin
                        shreg <= {dio, shreg[CODE_W-1:1]};
                        if (idx == IDX_LAST) begin
                            state <= MS_IDLE;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: state <= MS_IDLE;
            endcase
        end
    end

    assert_hit_rearms_R11: assert property (@(posedge clk) disable iff (rst)
        code_hit |=> (state == MS_IDLE));

    assert_armed_by_high_R2: assert property (@(posedge clk) disable iff (rst)
        (state == MS_ARMED) |-> $past(dio));

    assert_collect_index_R6: assert property (@(posedge clk) disable iff (rst)
        (state == MS_COLLECT) |-> (idx != '0));

    assert_full_code_R3: assert property (@(posedge clk) disable iff (rst)
        code_hit |=> (shreg == $past(exp_code)));

endmodule

// File: rtl/dbg_mode_switch_detector.sv
module dbg_mode_switch_detector #(
    parameter int unsigned RUN_LEN             = dbgsw_pkg::DFLT_RUN_LEN,
    parameter int unsigned CODE_W              = dbgsw_pkg::SW_CODE_W,
    parameter logic [CODE_W-1:0] TO_SERIAL_CODE = dbgsw_pkg::CODE_JTAG_TO_SERIAL,
    parameter logic [CODE_W-1:0] TO_JTAG_CODE   = dbgsw_pkg::CODE_SERIAL_TO_JTAG,
    localparam int unsigned CW                  = $clog2(RUN_LEN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic dio_i,
    output logic port_serial_o,
    output logic line_reset_o,
    output logic mode_changed_o
);
    import dbgsw_pkg::*;

    port_status_t      st;
    logic [CW-1:0]     run_cnt;
    logic              arm_now;
    logic              reach_now;
    logic              code_hit;
    logic [CODE_W-1:0] exp_code;

    hi_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
        .clk       (clk),
        .rst       (rst),
        .dio       (dio_i),
        .run_cnt   (run_cnt),
        .arm_now   (arm_now),
        .reach_now (reach_now)
    );

    assign exp_code = (st.mode == PORT_SERIAL) ? TO_JTAG_CODE : TO_SERIAL_CODE;

    code_matcher #(.CODE_W(CODE_W)) u_match (
        .clk      (clk),
        .rst      (rst),
        .dio      (dio_i),
        .arm_now  (arm_now),
        .exp_code (exp_code),
        .code_hit (code_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{mode: PORT_JTAG, line_rst: 1'b0, mode_chg: 1'b0};
        end else begin
            st.mode_chg <= code_hit;
            st.line_rst <= reach_now && (st.mode == PORT_SERIAL);
            if (code_hit) begin
                st.mode <= (st.mode == PORT_SERIAL) ? PORT_JTAG : PORT_SERIAL;
            end
        end
    end

    assign port_serial_o  = (st.mode == PORT_SERIAL);
    assign line_reset_o   = st.line_rst;
    assign mode_changed_o = st.mode_chg;

    assert_flip_has_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (port_serial_o != $past(port_serial_o)) |-> mode_changed_o);

    assert_pulse_has_flip_R7: assert property (@(posedge clk) disable iff (rst)
        mode_changed_o |-> (port_serial_o != $past(port_serial_o)));

    assert_mc_single_R4: assert property (@(posedge clk) disable iff (rst)
        mode_changed_o |=> !mode_changed_o);

    assert_lr_single_R8: assert property (@(posedge clk) disable iff (rst)
        line_reset_o |=> !line_reset_o);

    assert_lr_serial_only_R8: assert property (@(posedge clk) disable iff (rst)
        line_reset_o |-> $past(port_serial_o));

endmodule

// File: tb/tb_dbg_mode_switch_detector.sv
`timescale 1ns/1ps
module tb_dbg_mode_switch_detector;

    localparam logic [15:0] C_TO_SER = 16'hE79E;
    localparam logic [15:0] C_TO_JTG = 16'hE73C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dio = 1'b0;
    logic port_serial, line_reset, mode_changed;

    always #4 clk = ~clk;

    dbg_mode_switch_detector dut (
        .clk            (clk),
        .rst            (rst),
        .dio_i          (dio),
        .port_serial_o  (port_serial),
        .line_reset_o   (line_reset),
        .mode_changed_o (mode_changed)
    );

    int    n_cmp  = 0;
    int    n_bad  = 0;
    int    lr_seen = 0;
    int    mc_seen = 0;
    string req = "R1";

    // Reference model state
    logic  hist[$];
    int    m_run = 0;
    bit    m_ser = 0;
    bit    e_lr, e_mc;

    function automatic bit window_hits(input logic [15:0] c);
        if (hist.size() < 66) return 0;
        for (int k = 0; k < 50; k++) if (hist[k] !== 1'b1) return 0;
        for (int k = 0; k < 16; k++) if (hist[50+k] !== c[k]) return 0;
        return 1;
    endfunction

    task automatic check(input string r, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
        end
    endtask

    task automatic step(input logic b);
        bit hit;
        dio = b;
        hist.push_back(b);
        if (hist.size() > 66) void'(hist.pop_front());
        if (b) m_run++; else m_run = 0;
        e_lr = (m_run == 50) && m_ser;
        hit  = window_hits(m_ser ? C_TO_JTG : C_TO_SER);
        e_mc = hit;
        if (hit) m_ser = !m_ser;
        @(posedge clk);
        #1;
        check({req, " mode"}, port_serial, m_ser);
        check({req, " line_reset"}, line_reset, e_lr);
        check({req, " mode_changed"}, mode_changed, e_mc);
        lr_seen += line_reset;
        mc_seen += mode_changed;
    endtask

    task automatic highs(input int n);
        for (int i = 0; i < n; i++) step(1'b1);
    endtask

    task automatic send_code(input logic [15:0] c, input int flip);
        for (int i = 0; i < 16; i++) step((i == flip) ? ~c[i] : c[i]);
    endtask

    task automatic clear_counts();
        lr_seen = 0;
        mc_seen = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 mode in reset", port_serial, 0);
        check("R1 line_reset in reset", line_reset, 0);
        check("R1 mode_changed in reset", mode_changed, 0);
        rst = 1'b0;
        step(1'b0);

        // R5: one sample short of the run
        req = "R5"; clear_counts();
        highs(49); send_code(C_TO_SER, -1); step(1'b0);
        check("R5 no switch after 49 highs", port_serial, 0);
        check("R5 no pulse", mc_seen, 0);

        // R2: a low splits the run
        req = "R2"; clear_counts();
        highs(30); step(1'b0); highs(30); send_code(C_TO_SER, -1); step(1'b0);
        check("R2 split run does not qualify", port_serial, 0);

        // R3 / R9: switch to serial, flag updated without trailing run
        req = "R3"; clear_counts();
        highs(50); send_code(C_TO_SER, -1);
        check("R9 flag set right after code", port_serial, 1);
        check("R3 one mode pulse", mc_seen, 1);
        req = "R8"; clear_counts();
        highs(50);
        check("R8 trailing run line reset", lr_seen, 1);

        // R8 / R10: long run gives one line reset
        clear_counts(); req = "R10";
        step(1'b0); highs(200);
        check("R8 single line reset over long run", lr_seen, 1);

        // R7: wrong-direction code
        req = "R7"; clear_counts();
        send_code(C_TO_SER, -1); step(1'b0);
        check("R7 same-direction code ignored mode", port_serial, 1);
        check("R7 no mode pulse", mc_seen, 0);

        // R6: corrupted code then immediate correct code
        req = "R6"; clear_counts();
        highs(60); send_code(C_TO_JTG, 5); send_code(C_TO_JTG, -1); step(1'b0);
        check("R6 abandoned code needs new run", port_serial, 1);
        check("R6 no mode pulse", mc_seen, 0);

        // R4 then R11
        req = "R4"; clear_counts();
        highs(60); send_code(C_TO_JTG, -1);
        check("R4 back to jtag", port_serial, 0);
        check("R4 one mode pulse", mc_seen, 1);
        req = "R11"; clear_counts();
        send_code(C_TO_SER, -1); step(1'b0);
        check("R11 code without new run ignored", port_serial, 0);
        req = "R8"; clear_counts();
        highs(60); step(1'b0);
        check("R8 no line reset in jtag", lr_seen, 0);

        // R10: very long run still qualifies
        req = "R10"; clear_counts();
        highs(300); send_code(C_TO_SER, -1); highs(55);
        check("R10 long run then code switches", port_serial, 1);
        check("R10 line reset after switch", lr_seen, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule